// File: doc/BRIEF.md
# Dual-Coverage Packet CRC Engine

This block protects a byte stream with two cyclic redundancy checks computed side by side in a single pass. An end-to-end code of 32 bits covers only the bytes that no hop may rewrite. Each byte carries a flag that marks it as rewritable, and such bytes enter the 32-bit code as 0xFF. A per-hop code of 16 bits covers every byte as it actually travels, including the four bytes of the end-to-end code. A hop can therefore rewrite a flagged field and regenerate only the 16-bit code. The end-to-end code still verifies at the far end.

The transmit path forwards each packet and appends a six-byte trailer: four end-to-end bytes, then two per-hop bytes. While it emits the trailer it holds its input ready low. The receive path recomputes both codes over an incoming packet. In the cycle after the end byte it gives a one-cycle verdict that separates three outcomes: a good packet, a per-hop failure and an end-to-end failure.

Transmit states: `TX_IDLE` (waiting for a start byte), `TX_BODY` (forwarding packet bytes), `TX_E2E` (emitting the four end-to-end bytes) and `TX_HOP` (emitting the two per-hop bytes).
- `TX_IDLE` goes to `TX_BODY` on a start byte, or straight to `TX_E2E` if that byte is also the end byte.
- `TX_BODY` goes to `TX_E2E` on the end byte. A start byte in `TX_BODY` restarts both codes.
- `TX_E2E` goes to `TX_HOP` after four bytes.
- `TX_HOP` goes back to `TX_IDLE` after two bytes.

Receive states: `RX_IDLE`, `RX_BODY` (collecting packet bytes) and `RX_REPORT` (one cycle of verdict).
- `RX_IDLE` or `RX_REPORT` goes to `RX_BODY` on a start byte, or to `RX_REPORT` if that byte is also the end byte. Otherwise they go to `RX_IDLE`.
- `RX_BODY` goes to `RX_REPORT` on the end byte. A start byte in `RX_BODY` restarts the packet.

Top module: `dual_crc_engine`

## Requirements
- R1: The end-to-end code is the reflected CRC with polynomial 0x04C11DB7, seed 0xFFFFFFFF and final inversion. It is taken over the packet bytes, with every flagged (variant) byte replaced by 0xFF. It is sent least significant byte first, as trailer bytes 1 to 4.
- R2: The per-hop code uses polynomial 0x100B and seed 0xFFFF. Each byte is shifted in most significant bit first, and there is no final inversion. It is taken over the real values of all packet bytes followed by the four end-to-end bytes. It is sent high byte first, as trailer bytes 5 and 6.
- R3: Transmit timing and markers:
  - Each accepted packet byte appears unchanged on the transmit output one cycle after it is accepted.
  - The first byte carries the start marker.
  - The six trailer bytes follow back to back.
  - The end marker appears only on the last trailer byte.
- R4: After the transmit path accepts an end byte, tx_in_ready is low for exactly six cycles.
- R5: While the transmit path is idle, a valid byte without the start marker is dropped and produces no output. A start byte in the middle of a packet starts a new packet: the codes cover only the bytes from the new start onward.
- R6: Receive verdict:
  - One cycle after the receive path accepts an end byte, rx_stat_valid is high for one cycle.
  - rx_stat_err bit 0 reports a per-hop mismatch and bit 1 an end-to-end mismatch.
  - A packet exactly as produced by the transmit path gives 00.
  - The variant flag must be low on the six trailer bytes.
- R7: If a variant-flagged byte changes value, the verdict depends only on the per-hop code. With the per-hop code regenerated, the verdict is 00. Without regeneration, it is 01.
- R8: If a byte that is not flagged changes value, bit 1 is set. The verdict is 10 when the per-hop code was regenerated and 11 when it was not.
- R9: A received packet shorter than six bytes gives the verdict 11.
- R10: While the receive path is not inside a packet, a valid byte without the start marker is ignored and produces no verdict.
- R11: During and right after reset, tx_out_valid and rx_stat_valid are low and tx_in_ready is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tx_in_valid | input | 1 | Transmit input byte valid |
| tx_in_ready | output | 1 | Transmit path can take a byte |
| tx_in_data | input | 8 | Transmit input byte |
| tx_in_first | input | 1 | Byte starts a packet |
| tx_in_last | input | 1 | Byte ends a packet |
| tx_in_variant | input | 1 | Byte is rewritable by hops |
| tx_out_valid | output | 1 | Transmit output byte valid |
| tx_out_data | output | 8 | Transmit output byte |
| tx_out_first | output | 1 | Output byte starts a packet |
| tx_out_last | output | 1 | Output byte ends a packet (last trailer byte) |
| rx_in_valid | input | 1 | Receive input byte valid |
| rx_in_data | input | 8 | Receive input byte |
| rx_in_first | input | 1 | Byte starts a packet |
| rx_in_last | input | 1 | Byte ends a packet |
| rx_in_variant | input | 1 | Byte is rewritable by hops |
| rx_stat_valid | output | 1 | Verdict valid, one cycle |
| rx_stat_err | output | 2 | Bit 0 per-hop failure, bit 1 end-to-end failure |

## Verification
Random packets of 1 to 24 bytes with random variant flags are framed by the transmit path. Their trailers are compared with codes computed in the bench, which separates the masked 32-bit code from the unmasked 16-bit one. Each frame is then received four ways:
- a flagged byte changed, with and without a regenerated per-hop code;
- a fixed byte changed, with and without a regenerated per-hop code.

These cases tell a per-hop rewrite apart from a true end-to-end corruption. Directed cases add the following, which exercise the packet-boundary handling:
- all-variant and no-variant packets;
- an empty body;
- packets too short to hold a trailer;
- stray bytes outside a packet;
- a restart in the middle of a packet.

// File: rtl/dual_crc_pkg.sv
package dual_crc_pkg;
    localparam int BYTE_W = 8;

    // End-to-end code
    localparam int          E2E_W       = 32;
    localparam logic [31:0] E2E_POLY    = 32'h04C1_1DB7;
    localparam logic [31:0] E2E_SEED    = 32'hFFFF_FFFF;
    localparam logic [31:0] E2E_RESIDUE = 32'hDEBB_20E3;

    // Per-hop code
    localparam int          HOP_W    = 16;
    localparam logic [15:0] HOP_POLY = 16'h100B;
    localparam logic [15:0] HOP_SEED = 16'hFFFF;

    localparam int E2E_BYTES     = E2E_W / BYTE_W;
    localparam int HOP_BYTES     = HOP_W / BYTE_W;
    localparam int TRAILER_BYTES = E2E_BYTES + HOP_BYTES;

    typedef enum logic [1:0] {TX_IDLE, TX_BODY, TX_E2E, TX_HOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_BODY, RX_REPORT} rx_state_t;

    typedef struct packed {
        logic              mask;
        logic [BYTE_W-1:0] data;
    } lag_t;
endpackage

// File: rtl/crc_lane.sv
module crc_lane #(
    parameter int           W       = 16,
    parameter logic [W-1:0] POLY    = '0,
    parameter logic [W-1:0] SEED    = '1,
    parameter bit           REFLECT = 1'b0,
    parameter int           BW      = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          step,
    input  logic [BW-1:0] din,
    output logic [W-1:0]  crc_q
);
    function automatic logic [W-1:0] bit_rev(input logic [W-1:0] x);
        logic [W-1:0] r;
        for (int i = 0; i < W; i++) r[i] = x[W-1-i];
        return r;
    endfunction

    localparam logic [W-1:0] POLY_REV = bit_rev(POLY);

    logic [W-1:0] base;
    logic [W-1:0] nxt;

    assign base = clear ? SEED : crc_q;

    generate
        if (REFLECT) begin : g_lsb_first
            always_comb begin
                nxt = base ^ W'(din);
                for (int b = 0; b < BW; b++)
                    nxt = nxt[0] ? ((nxt >> 1) ^ POLY_REV) : (nxt >> 1);
            end
        end else begin : g_msb_first
            always_comb begin
                nxt = base ^ {din, {(W-BW){1'b0}}};
                for (int b = 0; b < BW; b++)
                    nxt = nxt[W-1] ? ((nxt << 1) ^ POLY) : (nxt << 1);
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (!rst_n)     crc_q <= SEED;
        else if (step)  crc_q <= nxt;
        else if (clear) crc_q <= SEED;
    end
endmodule

// File: rtl/dual_crc_tx.sv
module dual_crc_tx
    import dual_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_variant,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_first,
    output logic              out_last,
    output logic              open_o
);
    localparam int IDX_W = $clog2(E2E_BYTES);
    localparam logic [IDX_W-1:0] E2E_END = IDX_W'(E2E_BYTES - 1);
    localparam logic [IDX_W-1:0] HOP_END = IDX_W'(HOP_BYTES - 1);

    tx_state_t         state_q, state_d;
    logic [IDX_W-1:0]  idx_q;
    logic              take;
    logic [E2E_W-1:0]  e2e_q, e2e_fcs;
    logic [HOP_W-1:0]  hop_q;
    logic [BYTE_W-1:0] e2e_byte, hop_byte, hop_din, e2e_din;

    assign in_ready = (state_q == TX_IDLE) || (state_q == TX_BODY);
    assign take     = in_valid && in_ready && (in_first || state_q == TX_BODY);
    assign open_o   = (state_q == TX_BODY);

    assign e2e_fcs  = ~e2e_q;
    assign e2e_byte = BYTE_W'(e2e_fcs >> (BYTE_W * int'(idx_q)));
    assign hop_byte = BYTE_W'(hop_q >> (BYTE_W * (HOP_BYTES - 1 - int'(idx_q))));
    assign e2e_din  = in_variant ? {BYTE_W{1'b1}} : in_data;
    assign hop_din  = (state_q == TX_E2E) ? e2e_byte : in_data;

    crc_lane #(.W(E2E_W), .POLY(E2E_POLY), .SEED(E2E_SEED), .REFLECT(1'b1), .BW(BYTE_W)) u_e2e (
        .clk(clk), .rst_n(rst_n), .clear(take && in_first), .step(take),
        .din(e2e_din), .crc_q(e2e_q)
    );

    crc_lane #(.W(HOP_W), .POLY(HOP_POLY), .SEED(HOP_SEED), .REFLECT(1'b0), .BW(BYTE_W)) u_hop (
        .clk(clk), .rst_n(rst_n), .clear(take && in_first),
        .step(take || state_q == TX_E2E), .din(hop_din), .crc_q(hop_q)
    );

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            TX_IDLE, TX_BODY: begin
                if (take) state_d = in_last ? TX_E2E : TX_BODY;
            end
            TX_E2E:  if (idx_q == E2E_END) state_d = TX_HOP;
            TX_HOP:  if (idx_q == HOP_END) state_d = TX_IDLE;
            default: state_d = TX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= TX_IDLE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            idx_q   <= (state_d != state_q) ? '0 : idx_q + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_data  <= '0;
            out_first <= 1'b0;
            out_last  <= 1'b0;
        end else begin
            out_valid <= take || (state_q == TX_E2E) || (state_q == TX_HOP);
            out_first <= take && in_first;
            out_last  <= (state_q == TX_HOP) && (idx_q == HOP_END);
            unique case (state_q)
                TX_E2E:  out_data <= e2e_byte;
                TX_HOP:  out_data <= hop_byte;
                default: out_data <= in_data;
            endcase
        end
    end
endmodule

// File: rtl/dual_crc_rx.sv
module dual_crc_rx
    import dual_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_first,
    input  logic              in_last,
    input  logic              in_variant,
    output logic              stat_valid,
    output logic [1:0]        stat_err,
    output logic              open_o
);
    localparam int LAG   = HOP_BYTES;
    localparam int CNT_W = $clog2(TRAILER_BYTES + 1);
    localparam logic [CNT_W-1:0] CNT_FULL = CNT_W'(TRAILER_BYTES);

    rx_state_t         state_q, state_d;
    lag_t              lag_q [LAG];
    logic [LAG-1:0]    lag_v;
    logic [CNT_W-1:0]  cnt_q;
    logic              take, short_pkt;
    logic [E2E_W-1:0]  e2e_q;
    logic [HOP_W-1:0]  hop_q;
    logic [BYTE_W-1:0] e2e_din;

    assign take    = in_valid && (in_first || state_q == RX_BODY);
    assign open_o  = (state_q == RX_BODY);
    assign e2e_din = lag_q[LAG-1].mask ? {BYTE_W{1'b1}} : lag_q[LAG-1].data;

    // The end-to-end lane trails the input by the per-hop trailer length,
    // so the per-hop bytes never enter it.
    crc_lane #(.W(E2E_W), .POLY(E2E_POLY), .SEED(E2E_SEED), .REFLECT(1'b1), .BW(BYTE_W)) u_e2e (
        .clk(clk), .rst_n(rst_n), .clear(take && in_first),
        .step(take && !in_first && lag_v[LAG-1]), .din(e2e_din), .crc_q(e2e_q)
    );

    crc_lane #(.W(HOP_W), .POLY(HOP_POLY), .SEED(HOP_SEED), .REFLECT(1'b0), .BW(BYTE_W)) u_hop (
        .clk(clk), .rst_n(rst_n), .clear(take && in_first), .step(take),
        .din(in_data), .crc_q(hop_q)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lag_v <= '0;
            cnt_q <= '0;
            for (int i = 0; i < LAG; i++) lag_q[i] <= '0;
        end else if (take) begin
            lag_q[0] <= '{mask: in_variant, data: in_data};
            for (int i = 1; i < LAG; i++) lag_q[i] <= lag_q[i-1];
            lag_v <= in_first ? LAG'(1) : {lag_v[LAG-2:0], 1'b1};
            if (in_first)             cnt_q <= CNT_W'(1);
            else if (cnt_q != CNT_FULL) cnt_q <= cnt_q + 1'b1;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RX_IDLE, RX_REPORT: begin
                if (take) state_d = in_last ? RX_REPORT : RX_BODY;
                else      state_d = RX_IDLE;
            end
            RX_BODY: if (take && in_last) state_d = RX_REPORT;
            default: state_d = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= RX_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        short_pkt  = (cnt_q < CNT_FULL);
        stat_valid = (state_q == RX_REPORT);
        stat_err   = '0;
        if (stat_valid) begin
            stat_err[0] = short_pkt || (hop_q != '0);
            stat_err[1] = short_pkt || (e2e_q != E2E_RESIDUE);
        end
    end
endmodule

// File: rtl/dual_crc_engine.sv
module dual_crc_engine
    import dual_crc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tx_in_valid,
    output logic              tx_in_ready,
    input  logic [BYTE_W-1:0] tx_in_data,
    input  logic              tx_in_first,
    input  logic              tx_in_last,
    input  logic              tx_in_variant,
    output logic              tx_out_valid,
    output logic [BYTE_W-1:0] tx_out_data,
    output logic              tx_out_first,
    output logic              tx_out_last,
    input  logic              rx_in_valid,
    input  logic [BYTE_W-1:0] rx_in_data,
    input  logic              rx_in_first,
    input  logic              rx_in_last,
    input  logic              rx_in_variant,
    output logic              rx_stat_valid,
    output logic [1:0]        rx_stat_err
);
    logic tx_open;
    logic rx_open;

    dual_crc_tx u_tx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(tx_in_valid), .in_ready(tx_in_ready), .in_data(tx_in_data),
        .in_first(tx_in_first), .in_last(tx_in_last), .in_variant(tx_in_variant),
        .out_valid(tx_out_valid), .out_data(tx_out_data),
        .out_first(tx_out_first), .out_last(tx_out_last), .open_o(tx_open)
    );

    dual_crc_rx u_rx (
        .clk(clk), .rst_n(rst_n),
        .in_valid(rx_in_valid), .in_data(rx_in_data), .in_first(rx_in_first),
        .in_last(rx_in_last), .in_variant(rx_in_variant),
        .stat_valid(rx_stat_valid), .stat_err(rx_stat_err), .open_o(rx_open)
    );
endmodule

// File: rtl/dual_crc_engine_chk.sv
module dual_crc_engine_chk (
    input logic clk,
    input logic rst_n,
    input logic tx_in_valid,
    input logic tx_in_ready,
    input logic tx_in_first,
    input logic tx_in_last,
    input logic tx_out_valid,
    input logic tx_out_first,
    input logic tx_out_last,
    input logic rx_in_valid,
    input logic rx_in_first,
    input logic rx_in_last,
    input logic rx_stat_valid,
    input logic tx_open,
    input logic rx_open
);
    AST_TAIL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_ready && tx_in_last && (tx_in_first || tx_open)) |=> !tx_in_ready); // R4

    AST_TAIL_END: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_last |-> (!$past(tx_in_ready) && $past(tx_out_valid, 5))); // R3

    AST_FIRST_MARK: assert property (@(posedge clk) disable iff (!rst_n)
        tx_out_first |-> (tx_out_valid && !tx_out_last)); // R3

    AST_TX_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_in_valid && tx_in_ready && !tx_in_first && !tx_open) |=> !tx_out_valid); // R5

    AST_VERDICT_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stat_valid |-> $past(rx_in_valid && rx_in_last && (rx_in_first || rx_open))); // R6

    AST_VERDICT_DUE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && rx_in_last && (rx_in_first || rx_open)) |=> rx_stat_valid); // R6

    AST_RX_STRAY: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_in_valid && !rx_in_first && !rx_open) |=> !rx_stat_valid); // R10
endmodule

bind dual_crc_engine dual_crc_engine_chk u_chk (
    .clk(clk), .rst_n(rst_n),
    .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready),
    .tx_in_first(tx_in_first), .tx_in_last(tx_in_last),
    .tx_out_valid(tx_out_valid), .tx_out_first(tx_out_first), .tx_out_last(tx_out_last),
    .rx_in_valid(rx_in_valid), .rx_in_first(rx_in_first), .rx_in_last(rx_in_last),
    .rx_stat_valid(rx_stat_valid), .tx_open(tx_open), .rx_open(rx_open)
);

// File: tb/tb_dual_crc_engine.sv
module tb_dual_crc_engine;
    logic       clk = 1'b0;
    logic       rst_n;
    logic       tx_in_valid, tx_in_ready, tx_in_first, tx_in_last, tx_in_variant;
    logic [7:0] tx_in_data;
    logic       tx_out_valid, tx_out_first, tx_out_last;
    logic [7:0] tx_out_data;
    logic       rx_in_valid, rx_in_first, rx_in_last, rx_in_variant;
    logic [7:0] rx_in_data;
    logic       rx_stat_valid;
    logic [1:0] rx_stat_err;

    always #5 clk = ~clk;

    dual_crc_engine dut (
        .clk(clk), .rst_n(rst_n),
        .tx_in_valid(tx_in_valid), .tx_in_ready(tx_in_ready), .tx_in_data(tx_in_data),
        .tx_in_first(tx_in_first), .tx_in_last(tx_in_last), .tx_in_variant(tx_in_variant),
        .tx_out_valid(tx_out_valid), .tx_out_data(tx_out_data),
        .tx_out_first(tx_out_first), .tx_out_last(tx_out_last),
        .rx_in_valid(rx_in_valid), .rx_in_data(rx_in_data), .rx_in_first(rx_in_first),
        .rx_in_last(rx_in_last), .rx_in_variant(rx_in_variant),
        .rx_stat_valid(rx_stat_valid), .rx_stat_err(rx_stat_err)
    );

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    logic [7:0] txo[$];
    bit         txl[$];
    bit         txf[$];

    always @(negedge clk) begin
        if (rst_n && tx_out_valid) begin
            txo.push_back(tx_out_data);
            txl.push_back(tx_out_last);
            txf.push_back(tx_out_first);
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] e2e_step(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r = c ^ {24'h0, b};
        for (int i = 0; i < 8; i++) r = r[0] ? ((r >> 1) ^ 32'hEDB8_8320) : (r >> 1);
        return r;
    endfunction

    function automatic logic [15:0] hop_step(input logic [15:0] c, input logic [7:0] b);
        logic [15:0] r = c ^ {b, 8'h00};
        for (int i = 0; i < 8; i++) r = r[15] ? ((r << 1) ^ 16'h100B) : (r << 1);
        return r;
    endfunction

    // Appends the per-hop code over every byte of f (f holds body plus end-to-end bytes).
    function automatic void add_hop(ref logic [7:0] f[$]);
        logic [15:0] h = 16'hFFFF;
        foreach (f[i]) h = hop_step(h, f[i]);
        f.push_back(h[15:8]);
        f.push_back(h[7:0]);
    endfunction

    function automatic void build_frame(input logic [7:0] d[$], input bit v[$], output logic [7:0] f[$]);
        logic [31:0] c = 32'hFFFF_FFFF;
        f = d;
        foreach (d[i]) c = e2e_step(c, v[i] ? 8'hFF : d[i]);
        c = ~c;
        for (int i = 0; i < 4; i++) f.push_back(c[8*i +: 8]);
        add_hop(f);
    endfunction

    function automatic void regen_hop(ref logic [7:0] f[$]);
        void'(f.pop_back());
        void'(f.pop_back());
        add_hop(f);
    endfunction

    task automatic tx_send(input logic [7:0] d[$], input bit v[$], input bit close);
        int lo;
        foreach (d[i]) begin
            @(negedge clk);
            while (!tx_in_ready) @(negedge clk);
            tx_in_valid   = 1'b1;
            tx_in_data    = d[i];
            tx_in_variant = v[i];
            tx_in_first   = (i == 0);
            tx_in_last    = close && (i == d.size() - 1);
        end
        @(negedge clk);
        tx_in_valid = 1'b0;
        tx_in_first = 1'b0;
        tx_in_last  = 1'b0;
        if (close) begin
            lo = 0;
            while (!tx_in_ready && lo < 20) begin
                lo++;
                @(negedge clk);
            end
            chk(lo == 6, "R4 ready low cycles", lo, 6);
            @(negedge clk);
        end
    endtask

    // Compares txo from position base against frame f.
    task automatic tx_compare(input logic [7:0] f[$], input int base);
        int n = f.size();
        chk(txo.size() == base + n, "R3 output length", txo.size(), base + n);
        for (int i = 0; i < n && base + i < txo.size(); i++) begin
            if (i < n - 6)       chk(txo[base+i] == f[i], "R3 data echo", txo[base+i], f[i]);
            else if (i < n - 2)  chk(txo[base+i] == f[i], "R1 end-to-end byte", txo[base+i], f[i]);
            else                 chk(txo[base+i] == f[i], "R2 per-hop byte", txo[base+i], f[i]);
            chk(txl[base+i] == (i == n - 1), "R3 end marker", txl[base+i], (i == n - 1));
            chk(txf[base+i] == (i == 0), "R3 start marker", txf[base+i], (i == 0));
        end
    endtask

    task automatic rx_send(input logic [7:0] f[$], input bit v[$], input logic [1:0] exp, input string req);
        foreach (f[i]) begin
            @(negedge clk);
            rx_in_valid   = 1'b1;
            rx_in_data    = f[i];
            rx_in_variant = (i < v.size()) ? v[i] : 1'b0;
            rx_in_first   = (i == 0);
            rx_in_last    = (i == f.size() - 1);
        end
        @(negedge clk);
        rx_in_valid = 1'b0;
        rx_in_first = 1'b0;
        rx_in_last  = 1'b0;
        chk(rx_stat_valid == 1'b1, req, rx_stat_valid, 1);
        chk(rx_stat_err == exp, req, rx_stat_err, exp);
        @(negedge clk);
        chk(rx_stat_valid == 1'b0, "R6 one-cycle verdict", rx_stat_valid, 0);
    endtask

    logic [7:0] d[$], f[$], g[$], d2[$], f2[$];
    bit         v[$], fv[$], v2[$];

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        int vi, ii, len;
        logic [7:0] nz;
        tx_in_valid = 0; tx_in_data = 0; tx_in_first = 0; tx_in_last = 0; tx_in_variant = 0;
        rx_in_valid = 0; rx_in_data = 0; rx_in_first = 0; rx_in_last = 0; rx_in_variant = 0;
        rst_n = 1'b0;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        chk(tx_out_valid == 0, "R11 tx_out_valid in reset", tx_out_valid, 0);
        chk(rx_stat_valid == 0, "R11 rx_stat_valid in reset", rx_stat_valid, 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(tx_in_ready == 1, "R11 tx_in_ready after reset", tx_in_ready, 1);
        chk(tx_out_valid == 0, "R11 tx_out_valid after reset", tx_out_valid, 0);

        // R5: stray transmit byte while idle
        tx_in_valid = 1; tx_in_data = 8'h5A;
        @(negedge clk);
        tx_in_valid = 0;
        repeat (3) @(negedge clk);
        chk(txo.size() == 0, "R5 stray tx byte dropped", txo.size(), 0);

        // R10: stray receive bytes while idle
        for (int k = 0; k < 3; k++) begin
            rx_in_valid = 1; rx_in_data = 8'(k); rx_in_last = (k == 2);
            @(negedge clk);
            chk(rx_stat_valid == 0, "R10 stray rx byte ignored", rx_stat_valid, 0);
        end
        rx_in_valid = 0; rx_in_last = 0;
        @(negedge clk);
        chk(rx_stat_valid == 0, "R10 stray rx byte ignored", rx_stat_valid, 0);

        // R1 boundary: empty body, trailer only
        d = {}; v = {};
        build_frame(d, v, f);
        chk(f[0] == 8'h00 && f[3] == 8'h00, "R1 empty-body code", {f[0], f[3]}, 0);
        rx_send(f, v, 2'b00, "R6 empty-body verdict");

        // R9: short packets
        for (int n = 1; n < 6; n++) begin
            g = {};
            for (int k = 0; k < n; k++) g.push_back(8'($urandom));
            fv = {};
            rx_send(g, fv, 2'b11, "R9 short packet verdict");
        end

        // R5: restart in the middle of a packet
        d = {8'h11, 8'h22, 8'h33}; v = {1'b0, 1'b0, 1'b0};
        tx_send(d, v, 1'b0);
        d2 = {8'hA1, 8'hB2, 8'hC3, 8'hD4, 8'hE5}; v2 = {1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
        tx_send(d2, v2, 1'b1);
        build_frame(d2, v2, f2);
        for (int k = 0; k < 3 && k < txo.size(); k++) begin
            chk(txo[k] == d[k], "R5 bytes before restart echoed", txo[k], d[k]);
            chk(txl[k] == 0 && txf[k] == (k == 0), "R5 markers before restart", {txf[k], txl[k]}, {k == 0, 1'b0});
        end
        tx_compare(f2, 3);
        txo = {}; txl = {}; txf = {};

        // Random and directed packets through transmit and receive
        for (int it = 0; it < 40; it++) begin
            len = 1 + $urandom_range(23);
            d = {}; v = {};
            for (int k = 0; k < len; k++) begin
                d.push_back(8'($urandom));
                if (it == 0)      v.push_back(1'b1);
                else if (it == 1) v.push_back(1'b0);
                else              v.push_back($urandom_range(3) == 0);
            end
            tx_send(d, v, 1'b1);
            @(negedge clk);
            build_frame(d, v, f);
            tx_compare(f, 0);
            txo = {}; txl = {}; txf = {};

            fv = v;
            for (int k = 0; k < 6; k++) fv.push_back(1'b0);
            rx_send(f, fv, 2'b00, "R6 clean frame verdict");

            vi = -1; ii = -1;
            foreach (v[k]) begin
                if (v[k] && vi < 0)  vi = k;
                if (!v[k] && ii < 0) ii = k;
            end
            nz = 8'(1 + $urandom_range(254));
            if (vi >= 0) begin
                g = f; g[vi] = g[vi] ^ nz;
                rx_send(g, fv, 2'b01, "R7 variant change, stale per-hop");
                regen_hop(g);
                rx_send(g, fv, 2'b00, "R7 variant change, regenerated per-hop");
            end
            if (ii >= 0) begin
                g = f; g[ii] = g[ii] ^ nz;
                rx_send(g, fv, 2'b11, "R8 fixed change, stale per-hop");
                regen_hop(g);
                rx_send(g, fv, 2'b10, "R8 fixed change, regenerated per-hop");
            end
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end
endmodule